// File: doc/BRIEF.md
# Acquisition Frame Builder

This block turns one snapshot of a front-end acquisition card into a fixed 256-bit frame once per acquisition period. When the period tick arrives, it samples eight per-channel counter values, eight 12-bit converter samples, the status bits and the card identifier strap. A sync pattern and a running serial number go in front of these fields, and a CRC-32 follows the 224-bit payload.

The frame leaves as eight 32-bit words on a valid/ready stream, with the most significant word first. The first word carries a start-of-frame marker and the last word an end-of-frame marker. The serial number lets the receiver spot lost frames. The CRC lets it reject corrupted frames. A sticky flag records any period tick that arrives before the previous frame has fully left the block.

Top module: `frame_builder`

## Requirements
- R1: After reset, `o_valid` and `o_overrun` are low, and the first frame sent carries serial number 0.
- R2: The payload, from bit 223 down to bit 0, is laid out as follows:
  - the 16-bit sync pattern (default 16'hA3C5);
  - the 10-bit card ID;
  - the 16-bit serial number;
  - 72 bits of counters, with channel 0 in the top 9 bits and channel 7 in the lowest 9 bits;
  - 96 bits of samples, with channel 0 in the top 12 bits;
  - the 8 counter status bits as given (bit 7 highest);
  - the 2 converter status bits;
  - 4 zero pad bits.
  
  On the input buses, channel k occupies bits [k*9 +: 9] of the counter bus and bits [k*12 +: 12] of the sample bus.
- R3: The last word is a CRC-32 over the 224 payload bits, taken MSB first. It uses polynomial 0x04C11DB7, starts from all ones, and is sent without reflection or final inversion.
- R4: A frame is eight words, payload bits [223:192] first, then the CRC word. `o_sof` is high only on the first word and `o_eof` only on the last. `o_valid` falls after the last word is accepted.
- R5: The serial number goes up by one, modulo 2^16, for each frame that is started.
- R6: The inputs are captured on the clock edge where the tick is seen. Input changes after that edge do not alter the frame.
- R7: A tick that arrives while a frame is still being sent is ignored and does not use up a serial number. It sets `o_overrun`, which stays high until reset.
- R8: While `o_valid` is high and `i_ready` is low, `o_data`, `o_sof` and `o_eof` hold their values.
- R9: A tick seen while idle raises `o_valid` from the next cycle, presenting the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_tick | input | 1 | Acquisition period tick |
| i_card_id | input | 10 | Card identifier strap |
| i_counts | input | 72 | Eight 9-bit counter values |
| i_samples | input | 96 | Eight 12-bit converter samples |
| i_cnt_stat | input | 8 | Per-channel counter status |
| i_adc_stat | input | 2 | Converter status |
| i_ready | input | 1 | Downstream accepts the word |
| o_valid | output | 1 | Word available |
| o_data | output | 32 | Frame word |
| o_sof | output | 1 | First word of frame |
| o_eof | output | 1 | Last word of frame |
| o_overrun | output | 1 | Sticky: tick arrived during a frame |

## Verification
The bench checks every word of frames built from several card IDs, data seeds, status patterns and irregular ready patterns. The inputs are inverted right after each tick, so a design that samples late or passes the inputs through combinationally would put the new values into the words. A second tick is sent in the middle of a frame. A design that restarts the frame, or that advances the serial number on that tick, would show a wrong payload, a wrong CRC or a skipped serial number in the next frame. A design that clears the overrun flag after the frame drains would lose the flag. A CRC with a wrong initial value, a wrong bit order or a final inversion would only show up in the eighth word, and that word is compared against a bit-serial reference.

// File: rtl/fb_pkg.sv
`timescale 1ns/1ps
package fb_pkg;
    localparam int NCH      = 8;
    localparam int CNT_W    = 9;
    localparam int ADC_W    = 12;
    localparam int ID_W     = 10;
    localparam int SEQ_W    = 16;
    localparam int SYNC_W   = 16;
    localparam int ADST_W   = 2;
    localparam int WORD_W   = 32;
    localparam int CRC_W    = 32;
    localparam int PAY_W    = 224;
    localparam int CNT_BUS  = NCH * CNT_W;
    localparam int ADC_BUS  = NCH * ADC_W;
    localparam int PAD_W    = PAY_W - (SYNC_W + ID_W + SEQ_W + CNT_BUS + ADC_BUS + NCH + ADST_W);
    localparam int FRAME_W  = PAY_W + CRC_W;
    localparam int NWORDS   = FRAME_W / WORD_W;
    localparam int PAY_WORDS = PAY_W / WORD_W;
    localparam int IDX_W    = $clog2(NWORDS);

    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    typedef struct packed {
        logic [SYNC_W-1:0]  sync;
        logic [ID_W-1:0]    card;
        logic [SEQ_W-1:0]   serial;
        logic [CNT_BUS-1:0] counts;
        logic [ADC_BUS-1:0] samples;
        logic [NCH-1:0]     cnt_stat;
        logic [ADST_W-1:0]  adc_stat;
        logic [PAD_W-1:0]   pad;
    } payload_t;

    // One word of CRC advance, most significant data bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc_in,
                                                  input logic [WORD_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/fb_pack.sv
`timescale 1ns/1ps
module fb_pack
    import fb_pkg::*;
#(
    parameter logic [SYNC_W-1:0] SYNC_PATTERN = 16'hA3C5
) (
    input  logic [ID_W-1:0]    i_card,
    input  logic [SEQ_W-1:0]   i_serial,
    input  logic [CNT_BUS-1:0] i_counts,
    input  logic [ADC_BUS-1:0] i_samples,
    input  logic [NCH-1:0]     i_cnt_stat,
    input  logic [ADST_W-1:0]  i_adc_stat,
    output payload_t           o_pay
);
    logic [CNT_BUS-1:0] cnt_field;
    logic [ADC_BUS-1:0] adc_field;

    // Channel 0 goes to the most significant slot of each field.
    for (genvar k = 0; k < NCH; k++) begin : g_chan
        assign cnt_field[(NCH-1-k)*CNT_W +: CNT_W] = i_counts[k*CNT_W +: CNT_W];
        assign adc_field[(NCH-1-k)*ADC_W +: ADC_W] = i_samples[k*ADC_W +: ADC_W];
    end

    always_comb begin
        o_pay.sync     = SYNC_PATTERN;
        o_pay.card     = i_card;
        o_pay.serial   = i_serial;
        o_pay.counts   = cnt_field;
        o_pay.samples  = adc_field;
        o_pay.cnt_stat = i_cnt_stat;
        o_pay.adc_stat = i_adc_stat;
        o_pay.pad      = '0;
    end
endmodule

// File: rtl/fb_crc32.sv
`timescale 1ns/1ps
module fb_crc32
    import fb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_clear,
    input  logic              i_en,
    input  logic [WORD_W-1:0] i_data,
    output logic [CRC_W-1:0]  o_crc
);
    always_ff @(posedge clk) begin
        if (rst || i_clear) o_crc <= CRC_INIT;
        else if (i_en)      o_crc <= crc_step(o_crc, i_data);
    end
endmodule

// File: rtl/fb_seq.sv
`timescale 1ns/1ps
module fb_seq
    import fb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             i_tick,
    input  logic             i_ready,
    output logic             o_valid,
    output logic [IDX_W-1:0] o_idx,
    output logic             o_start,
    output logic             o_fire,
    output logic             o_overrun,
    output logic [SEQ_W-1:0] o_serial
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

    logic busy;

    assign o_valid = busy;
    assign o_start = i_tick && !busy;
    assign o_fire  = busy && i_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            o_idx     <= '0;
            o_serial  <= '0;
            o_overrun <= 1'b0;
        end else begin
            if (o_start) begin
                busy     <= 1'b1;
                o_idx    <= '0;
                o_serial <= o_serial + 1'b1;
            end else if (o_fire) begin
                if (o_idx == LAST_IDX) busy <= 1'b0;
                o_idx <= o_idx + 1'b1;
            end
            if (i_tick && busy) o_overrun <= 1'b1;
        end
    end

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        o_overrun |=> o_overrun);
    p_hold_index_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !i_ready) |=> (busy && o_idx == $past(o_idx)));
    p_serial_step_r5: assert property (@(posedge clk) disable iff (rst)
        o_start |=> (o_serial == $past(o_serial) + 1'b1));
    p_frame_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (o_fire && o_idx == LAST_IDX && !i_tick) |=> !busy);
endmodule

// File: rtl/frame_builder.sv
`timescale 1ns/1ps
module frame_builder
    import fb_pkg::*;
#(
    parameter logic [SYNC_W-1:0] SYNC_PATTERN = 16'hA3C5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               i_tick,
    input  logic [ID_W-1:0]    i_card_id,
    input  logic [CNT_BUS-1:0] i_counts,
    input  logic [ADC_BUS-1:0] i_samples,
    input  logic [NCH-1:0]     i_cnt_stat,
    input  logic [ADST_W-1:0]  i_adc_stat,
    input  logic               i_ready,
    output logic               o_valid,
    output logic [WORD_W-1:0]  o_data,
    output logic               o_sof,
    output logic               o_eof,
    output logic               o_overrun
);
    logic [IDX_W-1:0]  idx;
    logic              start, fire;
    logic [SEQ_W-1:0]  serial;
    payload_t          pay_d, pay_q;
    logic [CRC_W-1:0]  crc;
    logic [WORD_W-1:0] words [NWORDS];

    fb_seq u_seq (
        .clk(clk), .rst(rst), .i_tick(i_tick), .i_ready(i_ready),
        .o_valid(o_valid), .o_idx(idx), .o_start(start), .o_fire(fire),
        .o_overrun(o_overrun), .o_serial(serial)
    );

    fb_pack #(.SYNC_PATTERN(SYNC_PATTERN)) u_pack (
        .i_card(i_card_id), .i_serial(serial), .i_counts(i_counts),
        .i_samples(i_samples), .i_cnt_stat(i_cnt_stat),
        .i_adc_stat(i_adc_stat), .o_pay(pay_d)
    );

    always_ff @(posedge clk) begin
        if (rst)        pay_q <= '0;
        else if (start) pay_q <= pay_d;
    end

    // Payload words are folded into the CRC as they are accepted, so the
    // remainder is ready when the final word slot is reached.
    fb_crc32 u_crc (
        .clk(clk), .rst(rst), .i_clear(start),
        .i_en(fire && (int'(idx) < PAY_WORDS)),
        .i_data(o_data), .o_crc(crc)
    );

    for (genvar w = 0; w < PAY_WORDS; w++) begin : g_word
        assign words[w] = pay_q[PAY_W-1-w*WORD_W -: WORD_W];
    end
    assign words[NWORDS-1] = crc;

    assign o_data = words[idx];
    assign o_sof  = o_valid && (idx == '0);
    assign o_eof  = o_valid && (idx == IDX_W'(NWORDS - 1));

    p_data_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !i_ready) |=> (o_valid && $stable(o_data) && $stable(o_sof) && $stable(o_eof)));
    p_markers_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(o_sof && o_eof) && ((o_sof || o_eof) -> o_valid));
    p_tick_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (i_tick && o_valid) |=> o_overrun);
    p_start_shows_first_r9: assert property (@(posedge clk) disable iff (rst)
        (i_tick && !o_valid) |=> (o_valid && o_sof));
endmodule

// File: tb/tb_frame_builder.sv
`timescale 1ns/1ps
module tb_frame_builder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        i_tick = 1'b0;
    logic [9:0]  i_card_id = '0;
    logic [71:0] i_counts = '0;
    logic [95:0] i_samples = '0;
    logic [7:0]  i_cnt_stat = '0;
    logic [1:0]  i_adc_stat = '0;
    logic        i_ready = 1'b0;
    logic        o_valid, o_sof, o_eof, o_overrun;
    logic [31:0] o_data;

    frame_builder dut (
        .clk(clk), .rst(rst), .i_tick(i_tick), .i_card_id(i_card_id),
        .i_counts(i_counts), .i_samples(i_samples), .i_cnt_stat(i_cnt_stat),
        .i_adc_stat(i_adc_stat), .i_ready(i_ready), .o_valid(o_valid),
        .o_data(o_data), .o_sof(o_sof), .o_eof(o_eof), .o_overrun(o_overrun)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0]  exp_seq = '0;
    logic [223:0] exp_pay;

    // {card[9:0], seed[15:0], status[9:0], spare[3:0], ready pattern[7:0]}
    localparam logic [47:0] VEC [4] = '{
        {10'h001, 16'h1234, 10'h3FF, 4'h0, 8'hFF},
        {10'h3FF, 16'hBEEF, 10'h000, 4'h0, 8'h5A},
        {10'h155, 16'h0000, 10'h2A5, 4'h0, 8'h33},
        {10'h2AA, 16'hFFFF, 10'h15A, 4'h0, 8'h81}
    };

    task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    function automatic logic [223:0] build(input logic [9:0] card, input logic [15:0] seq,
                                           input logic [71:0] cnt, input logic [95:0] adc,
                                           input logic [9:0] st);
        logic [71:0] cf;
        logic [95:0] af;
        for (int k = 0; k < 8; k++) begin
            cf[(7-k)*9 +: 9]   = cnt[k*9 +: 9];
            af[(7-k)*12 +: 12] = adc[k*12 +: 12];
        end
        return {16'hA3C5, card, seq, cf, af, st, 4'h0};
    endfunction

    function automatic logic [31:0] crc_ref(input logic [223:0] p);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int i = 223; i >= 0; i--) begin
            fb = c[31] ^ p[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    // Apply inputs, pulse the tick while idle, then scramble the inputs.
    task automatic send(input logic [9:0] card, input logic [15:0] seed, input logic [9:0] st);
        @(negedge clk);
        chk("R9 idle before tick", {31'b0, o_valid}, 32'd0);
        i_card_id = card;
        for (int k = 0; k < 8; k++) begin
            i_counts[k*9 +: 9]   = 9'(seed * (k + 3) + k * 37);
            i_samples[k*12 +: 12] = 12'(seed ^ (k * 291));
        end
        i_cnt_stat = st[9:2];
        i_adc_stat = st[1:0];
        exp_pay = build(card, exp_seq, i_counts, i_samples, st);
        i_tick = 1'b1;
        @(negedge clk);
        i_tick = 1'b0;
        chk("R9 valid after tick", {30'b0, o_valid, o_sof}, 32'd3);
        i_card_id = ~i_card_id;
        i_counts = ~i_counts;
        i_samples = ~i_samples;
        i_cnt_stat = ~i_cnt_stat;
        i_adc_stat = ~i_adc_stat;
    endtask

    task automatic drain(input logic [7:0] rpat, input string tag);
        int n = 0;
        logic [31:0] exp;
        for (int j = 0; j < 64 && n < 8; j++) begin
            i_ready = rpat[j % 8];
            #1;
            if (o_valid && i_ready) begin
                exp = (n < 7) ? exp_pay[223 - 32*n -: 32] : crc_ref(exp_pay);
                chk($sformatf("R2/R3/R5/R6/R8 %s word%0d", tag, n), o_data, exp);
                chk($sformatf("R4 %s markers word%0d", tag, n), {30'b0, o_sof, o_eof},
                    {30'b0, (n == 0), (n == 7)});
                n++;
            end
            @(negedge clk);
        end
        i_ready = 1'b0;
        chk({"R4 word count ", tag}, n, 8);
        chk({"R4 valid low after frame ", tag}, {31'b0, o_valid}, 32'd0);
        exp_seq = exp_seq + 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset valid/overrun", {30'b0, o_valid, o_overrun}, 32'd0);

        // Table-driven frames; the first carries serial 0 (R1).
        for (int v = 0; v < 4; v++) begin
            send(VEC[v][47:38], VEC[v][37:22], VEC[v][21:12]);
            drain(VEC[v][7:0], $sformatf("vec%0d", v));
        end
        chk("R7 no overrun yet", {31'b0, o_overrun}, 32'd0);

        // Tick during a frame: ignored, sticky overrun (R7).
        send(10'h0C3, 16'h5A5A, 10'h0F0);
        chk("R7 overrun before second tick", {31'b0, o_overrun}, 32'd0);
        i_tick = 1'b1;
        @(negedge clk);
        i_tick = 1'b0;
        chk("R7 overrun set", {31'b0, o_overrun}, 32'd1);
        drain(8'hFF, "overrun-frame");
        chk("R7 overrun sticky", {31'b0, o_overrun}, 32'd1);
        send(10'h200, 16'h0F0F, 10'h001);
        drain(8'h6D, "after-overrun");

        // Reset clears state and restarts serial numbering (R1).
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset clears overrun", {30'b0, o_valid, o_overrun}, 32'd0);
        exp_seq = '0;
        send(10'h111, 16'h7777, 10'h3C3);
        drain(8'hFF, "post-reset");

        finish_run();
    end
endmodule